// File: doc/BRIEF.md
# Paged Address Translator with Dirty Tracking

This block sits between a processor and main memory and turns logical addresses into physical ones. A logical address is 22 bits wide: the upper 12 bits name a logical page, the lower 10 bits are the byte offset within a 1 KB page. A fully associative table of 8 resident-page entries maps a page to an 8-bit physical frame. Each entry holds a valid flag, the page tag, the frame number, a write-permit flag and a modified flag.

Each request is registered on a clock edge, and the table is searched from the registered copy. In the next cycle the block either presents the physical address, or it raises a fault that aborts the processor's bus cycle. A write that completes sets the entry's modified flag. System software can then tell which pages must be written back before their frames are reused. Each fault records the logical address, the direction and the cause in a status register that the fault handler can read.

Software fills an entry through a load port. The same page can then be retried, and the retry completes. A single-cycle command clears every valid flag at once, and an index-selected readback port shows the contents of any entry.

Top module: `page_xlate`

## Requirements
- R1: After reset, `rsp_valid_o` is 0, every entry reads back with valid, tag, frame, write-permit and modified all 0, and the fault status registers are 0.
- R2: A request sampled with `req_valid_i` high on a rising edge produces `rsp_valid_o` high during the following cycle only. An idle cycle produces no response, and back-to-back requests produce back-to-back responses in order.
- R3: When the page tag `req_addr_i[21:10]` matches a valid entry, a read, or a write to an entry with write-permit 1, completes. `rsp_fault_o` is 0 and `rsp_paddr_o` is `{frame, req_addr_i[9:0]}`.
- R4: When no valid entry matches, `rsp_fault_o` is 1 in the response cycle and `rsp_paddr_o` is 0.
- R5: A write that hits an entry with write-permit 0 faults and leaves that entry's modified flag unchanged. A read of the same entry completes normally.
- R6: A completed write sets the modified flag of the entry it hit, and the flag reads back as 1 from the cycle after the response. A completed read leaves the flag unchanged.
- R7: Each fault loads `fault_addr_o` with the logical address, `fault_write_o` with 1 for a write or 0 for a read, and `fault_cause_o` with 2'b00 for not resident or 2'b01 for write-protect. These values are visible from the cycle after the response. Accesses that complete leave the status unchanged.
- R8: A load (`cfg_we_i`) writes valid, tag, frame and write-permit into entry `cfg_idx_i` and clears its modified flag. A retry of an access that faulted then completes with the new frame.
- R9: `cfg_inval_i` clears the valid flag of every entry in one cycle, and later accesses fault as not resident. If a load happens in the same cycle, the invalidate wins for the valid flag, while tag, frame and write-permit still load.
- R10: If several valid entries match the same page, the entry with the lowest index supplies the frame and the write-permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_addr_i | input | 22 | Logical byte address |
| req_write_i | input | 1 | 1 = write access |
| rsp_valid_o | output | 1 | Result of the previous cycle's request |
| rsp_fault_o | output | 1 | Bus-error abort for the access |
| rsp_paddr_o | output | 18 | Physical address, 0 on a fault |
| cfg_we_i | input | 1 | Load an entry |
| cfg_idx_i | input | 3 | Entry index for the load |
| cfg_valid_i | input | 1 | Valid flag to load |
| cfg_tag_i | input | 12 | Logical page to load |
| cfg_frame_i | input | 8 | Physical frame to load |
| cfg_wen_i | input | 1 | Write-permit flag to load |
| cfg_inval_i | input | 1 | Clear all valid flags |
| rd_idx_i | input | 3 | Entry index for readback |
| rd_valid_o | output | 1 | Readback: valid flag |
| rd_tag_o | output | 12 | Readback: page tag |
| rd_frame_o | output | 8 | Readback: frame |
| rd_wen_o | output | 1 | Readback: write-permit |
| rd_mod_o | output | 1 | Readback: modified flag |
| fault_addr_o | output | 22 | Logical address of the last fault |
| fault_write_o | output | 1 | Direction of the last fault |
| fault_cause_o | output | 2 | Cause of the last fault |

## Verification
A corrupted valid flag or tag shows up in the very next response cycle, as a false fault or as a wrong frame on `rsp_paddr_o`. A wrong modified flag causes no access to misbehave, so it appears only on the readback port, one cycle after the write's response. The bench therefore reads the entry back right after each write and each reload. A status register that was not captured, or that was overwritten, appears at the status outputs in the cycle after the response. The bench samples it there, both after faults and after accesses that complete.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    CAUSE_MISS  = 2'b00,
    CAUSE_WPROT = 2'b01
  } cause_e;
endpackage

// File: rtl/xlate_table.sv
module xlate_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 12,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic                              wr_vld_i,
  input  logic [TAG_W-1:0]                  wr_tag_i,
  input  logic [FRAME_W-1:0]                wr_frame_i,
  input  logic                              wr_wen_i,
  input  logic                              inval_i,
  input  logic                              mark_i,
  input  logic [IDX_W-1:0]                  mark_idx_i,
  input  logic [TAG_W-1:0]                  look_tag_i,
  output logic [ENTRIES-1:0]                hit_vec_o,
  output logic [ENTRIES-1:0]                vld_o,
  output logic [ENTRIES-1:0][TAG_W-1:0]     tag_o,
  output logic [ENTRIES-1:0][FRAME_W-1:0]   frame_o,
  output logic [ENTRIES-1:0]                wen_o,
  output logic [ENTRIES-1:0]                mod_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [IDX_W-1:0] MyIdx = IDX_W'(e);
    logic sel;
    assign sel = wr_i && (wr_idx_i == MyIdx);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[e]   <= 1'b0;
        tag_o[e]   <= '0;
        frame_o[e] <= '0;
        wen_o[e]   <= 1'b0;
        mod_o[e]   <= 1'b0;
      end else begin
        // invalidate overrides a same-cycle load of the valid flag
        if (inval_i)  vld_o[e] <= 1'b0;
        else if (sel) vld_o[e] <= wr_vld_i;
        if (sel) begin
          tag_o[e]   <= wr_tag_i;
          frame_o[e] <= wr_frame_i;
          wen_o[e]   <= wr_wen_i;
          mod_o[e]   <= 1'b0;
        end else if (mark_i && (mark_idx_i == MyIdx)) begin
          mod_o[e]   <= 1'b1;
        end
      end
    end

    assign hit_vec_o[e] = vld_o[e] && (tag_o[e] == look_tag_i);
  end
endmodule

// File: rtl/xlate_sel.sv
module xlate_sel #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [ENTRIES-1:0]              hit_vec_i,
  input  logic [ENTRIES-1:0][FRAME_W-1:0] frame_i,
  input  logic [ENTRIES-1:0]              wen_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                idx_o,
  output logic [FRAME_W-1:0]              frame_o,
  output logic                            wen_o
);
  // scan downward so the lowest matching index is kept
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign frame_o = frame_i[idx_o];
  assign wen_o   = wen_i[idx_o];
endmodule

// File: rtl/xlate_fault.sv
module xlate_fault #(
  parameter int unsigned LA_W = 22
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cap_i,
  input  logic [LA_W-1:0]      addr_i,
  input  logic                 write_i,
  input  xlate_pkg::cause_e    cause_i,
  output logic [LA_W-1:0]      addr_o,
  output logic                 write_o,
  output logic [1:0]           cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      write_o <= 1'b0;
      cause_o <= 2'b00;
    end else if (cap_i) begin
      addr_o  <= addr_i;
      write_o <= write_i;
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int unsigned LA_W    = 22,
  parameter int unsigned OFF_W   = 10,
  parameter int unsigned FRAME_W = 8,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned TAG_W  = LA_W - OFF_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [LA_W-1:0]    req_addr_i,
  input  logic               req_write_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [PA_W-1:0]    rsp_paddr_o,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_valid_i,
  input  logic [TAG_W-1:0]   cfg_tag_i,
  input  logic [FRAME_W-1:0] cfg_frame_i,
  input  logic               cfg_wen_i,
  input  logic               cfg_inval_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [FRAME_W-1:0] rd_frame_o,
  output logic               rd_wen_o,
  output logic               rd_mod_o,
  output logic [LA_W-1:0]    fault_addr_o,
  output logic               fault_write_o,
  output logic [1:0]         fault_cause_o
);
  import xlate_pkg::*;

  logic              req_vld_q, req_wr_q;
  logic [LA_W-1:0]   req_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_vld_q  <= 1'b0;
      req_wr_q   <= 1'b0;
      req_addr_q <= '0;
    end else begin
      req_vld_q <= req_valid_i;
      if (req_valid_i) begin
        req_wr_q   <= req_write_i;
        req_addr_q <= req_addr_i;
      end
    end
  end

  logic [ENTRIES-1:0]              hit_vec, vld_all, wen_all, mod_all;
  logic [ENTRIES-1:0][TAG_W-1:0]   tag_all;
  logic [ENTRIES-1:0][FRAME_W-1:0] frame_all;
  logic                            hit, hit_wen, miss, wprot, mark;
  logic [IDX_W-1:0]                hit_idx;
  logic [FRAME_W-1:0]              hit_frame;
  cause_e                          cause;

  xlate_table #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_vld_i   (cfg_valid_i),
    .wr_tag_i   (cfg_tag_i),
    .wr_frame_i (cfg_frame_i),
    .wr_wen_i   (cfg_wen_i),
    .inval_i    (cfg_inval_i),
    .mark_i     (mark),
    .mark_idx_i (hit_idx),
    .look_tag_i (req_addr_q[LA_W-1:OFF_W]),
    .hit_vec_o  (hit_vec),
    .vld_o      (vld_all),
    .tag_o      (tag_all),
    .frame_o    (frame_all),
    .wen_o      (wen_all),
    .mod_o      (mod_all)
  );

  xlate_sel #(
    .ENTRIES(ENTRIES), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
  ) u_sel (
    .hit_vec_i (hit_vec),
    .frame_i   (frame_all),
    .wen_i     (wen_all),
    .hit_o     (hit),
    .idx_o     (hit_idx),
    .frame_o   (hit_frame),
    .wen_o     (hit_wen)
  );

  assign miss  = req_vld_q && !hit;
  assign wprot = req_vld_q && hit && req_wr_q && !hit_wen;
  assign mark  = req_vld_q && hit && req_wr_q && hit_wen;
  assign cause = miss ? CAUSE_MISS : CAUSE_WPROT;

  assign rsp_valid_o = req_vld_q;
  assign rsp_fault_o = miss || wprot;
  assign rsp_paddr_o = (req_vld_q && !rsp_fault_o) ?
                       {hit_frame, req_addr_q[OFF_W-1:0]} : '0;

  xlate_fault #(.LA_W(LA_W)) u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (rsp_fault_o),
    .addr_i  (req_addr_q),
    .write_i (req_wr_q),
    .cause_i (cause),
    .addr_o  (fault_addr_o),
    .write_o (fault_write_o),
    .cause_o (fault_cause_o)
  );

  assign rd_valid_o = vld_all[rd_idx_i];
  assign rd_tag_o   = tag_all[rd_idx_i];
  assign rd_frame_o = frame_all[rd_idx_i];
  assign rd_wen_o   = wen_all[rd_idx_i];
  assign rd_mod_o   = mod_all[rd_idx_i];
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int unsigned LA_W  = 22,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned PA_W  = 18
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [LA_W-1:0] req_addr_i,
  input logic            req_write_i,
  input logic            rsp_valid_o,
  input logic            rsp_fault_o,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic [LA_W-1:0] fault_addr_o,
  input logic            fault_write_o,
  input logic [1:0]      fault_cause_o
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R2
  AST_FAULT_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_valid_o); // R4
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> rsp_paddr_o == '0); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |->
      rsp_paddr_o[OFF_W-1:0] == $past(req_addr_i[OFF_W-1:0])); // R3
  AST_STAT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |=> fault_addr_o == $past(req_addr_i, 2)); // R7
  AST_STAT_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |=> fault_write_o == $past(req_write_i, 2)); // R7
  AST_READ_FAULT_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && !$past(req_write_i)) |=> fault_cause_o == 2'b00); // R7
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_fault_o |=> $stable(fault_addr_o) && $stable(fault_cause_o)); // R7
endmodule

bind page_xlate page_xlate_chk #(.LA_W(LA_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_addr_i    (req_addr_i),
  .req_write_i   (req_write_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_fault_o   (rsp_fault_o),
  .rsp_paddr_o   (rsp_paddr_o),
  .fault_addr_o  (fault_addr_o),
  .fault_write_o (fault_write_o),
  .fault_cause_o (fault_cause_o)
);

// File: tb/page_xlate_bench.sv
`timescale 1ns/1ps
module page_xlate_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_write_i = 0;
  logic [21:0] req_addr_i = '0;
  logic rsp_valid_o, rsp_fault_o;
  logic [17:0] rsp_paddr_o;
  logic cfg_we_i = 0, cfg_valid_i = 0, cfg_wen_i = 0, cfg_inval_i = 0;
  logic [2:0] cfg_idx_i = '0, rd_idx_i = '0;
  logic [11:0] cfg_tag_i = '0;
  logic [7:0] cfg_frame_i = '0;
  logic rd_valid_o, rd_wen_o, rd_mod_o;
  logic [11:0] rd_tag_o;
  logic [7:0] rd_frame_o;
  logic [21:0] fault_addr_o;
  logic fault_write_o;
  logic [1:0] fault_cause_o;

  page_xlate u_page_xlate (.*);

  always #4 clk_i = ~clk_i;

  int n_vec = 0, n_bad = 0;
  logic [18:0] exp_q[$];
  string tag_q[$];

  // reference model of the table and status, kept by the bench
  logic m_vld[8], m_wen[8], m_mod[8];
  logic [11:0] m_tag[8];
  logic [7:0] m_frame[8];
  logic [21:0] m_fa = '0;
  logic m_fw = 0;
  logic [1:0] m_fc = 2'b00;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as responses appear
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) begin
        n_bad++; n_vec++;
        $display("FAIL R2 actual=response expected=none");
      end else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {13'd0, rsp_fault_o, rsp_paddr_o}, {13'd0, e});
      end
    end
  end

  task automatic load(int idx, logic v, logic [11:0] tg, logic [7:0] fr, logic we);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = 3'(idx); cfg_valid_i = v;
    cfg_tag_i = tg; cfg_frame_i = fr; cfg_wen_i = we;
    @(negedge clk_i);
    cfg_we_i = 0;
    m_vld[idx] = v; m_tag[idx] = tg; m_frame[idx] = fr; m_wen[idx] = we; m_mod[idx] = 0;
  endtask

  task automatic issue(logic [21:0] a, logic wr, string req);
    logic hit = 0, flt;
    int k = 0;
    for (int i = 0; i < 8; i++)
      if (!hit && m_vld[i] && m_tag[i] == a[21:10]) begin hit = 1; k = i; end
    flt = !hit || (wr && !m_wen[k]);
    exp_q.push_back({flt, flt ? 18'd0 : {m_frame[k], a[9:0]}});
    tag_q.push_back(req);
    if (!flt && wr) m_mod[k] = 1;
    if (flt) begin m_fa = a; m_fw = wr; m_fc = hit ? 2'b01 : 2'b00; end
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a; req_write_i = wr;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic access(logic [21:0] a, logic wr, string req);
    issue(a, wr, req);
    idle();
  endtask

  task automatic rb(int idx, string req);
    @(negedge clk_i);
    rd_idx_i = 3'(idx);
    #1;
    check(req, {8'd0, rd_valid_o, rd_tag_o, rd_frame_o, rd_wen_o, rd_mod_o},
               {8'd0, m_vld[idx], m_tag[idx], m_frame[idx], m_wen[idx], m_mod[idx]});
  endtask

  task automatic stat(string req);
    @(negedge clk_i);
    check(req, {7'd0, fault_cause_o, fault_write_o, fault_addr_o},
               {7'd0, m_fc, m_fw, m_fa});
  endtask

  initial begin
    repeat (25000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 0; m_wen[i] = 0; m_mod[i] = 0; m_tag[i] = '0; m_frame[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    check("R1 rsp_valid", {31'd0, rsp_valid_o}, 0);
    for (int i = 0; i < 8; i++) rb(i, "R1 entry");
    stat("R1 status");

    // R4 miss, R7 cause 00 read
    access({12'h155, 10'h2A7}, 0, "R4 miss");
    stat("R7 miss read");
    // R8 load then retry hits, R3
    load(2, 1, 12'h155, 8'h3A, 1);
    rb(2, "R8 loaded");
    access({12'h155, 10'h2A7}, 0, "R8 retry");
    rb(2, "R6 read leaves mod");
    access({12'h155, 10'h013}, 1, "R3 write hit");
    rb(2, "R6 mod set");
    stat("R7 hold after hits");

    // R5 write-protect
    load(5, 1, 12'h0F0, 8'h81, 0);
    access({12'h0F0, 10'h3FF}, 0, "R5 read protected ok");
    access({12'h0F0, 10'h001}, 1, "R5 write protected fault");
    rb(5, "R5 mod unchanged");
    stat("R7 wprot cause");
    access({12'hABC, 10'h100}, 1, "R4 write miss");
    stat("R7 write miss");

    // R8 reload clears modified
    load(2, 1, 12'h155, 8'h3A, 1);
    rb(2, "R8 mod cleared");

    // R10 duplicates: lowest index wins
    load(6, 1, 12'h155, 8'h99, 1);
    access({12'h155, 10'h055}, 0, "R10 idx2 over idx6");
    load(1, 1, 12'h155, 8'h11, 0);
    access({12'h155, 10'h055}, 1, "R10 idx1 wprot wins");

    // R2 back-to-back burst, mixed results
    load(0, 1, 12'h000, 8'hFF, 1);
    issue({12'h000, 10'h000}, 1, "R2 burst 0");
    issue({12'h0F0, 10'h222}, 0, "R2 burst 1");
    issue({12'h777, 10'h111}, 0, "R2 burst 2");
    issue({12'h000, 10'h3FF}, 0, "R2 burst 3");
    issue({12'h0F0, 10'h004}, 1, "R2 burst 4");
    issue({12'h155, 10'h200}, 0, "R2 burst 5");
    idle();
    rb(0, "R6 burst write");
    stat("R7 after burst");
    repeat (2) @(negedge clk_i);
    check("R2 idle no rsp", {31'd0, rsp_valid_o}, 0);

    // R9 invalidate, with a same-cycle load
    @(negedge clk_i);
    cfg_inval_i = 1; cfg_we_i = 1; cfg_idx_i = 3'd3; cfg_valid_i = 1;
    cfg_tag_i = 12'h321; cfg_frame_i = 8'h42; cfg_wen_i = 1;
    @(negedge clk_i);
    cfg_inval_i = 0; cfg_we_i = 0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
    m_tag[3] = 12'h321; m_frame[3] = 8'h42; m_wen[3] = 1; m_mod[3] = 0;
    for (int i = 0; i < 8; i++) rb(i, "R9 invalidated");
    access({12'h000, 10'h010}, 0, "R9 access after invalidate");
    access({12'h321, 10'h010}, 1, "R9 inval beat load");
    stat("R9 status");

    repeat (3) @(negedge clk_i);
    check("R2 queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule